// File: doc/BRIEF.md
# Counterflow Product-Term Plane with Streamed Programming

This block computes the AND plane of a programmable logic array in which no crosspoint holds a configuration bit. Each product row is a pipeline in which data waves move one stage per clock in one direction while programming tokens move one stage per clock in the other. Whenever a wave and a token meet, the token's instruction is applied to the wave's running product. A token either includes one literal in the product or has no effect on it. Because the program is a moving stream and not a stored register set, a new program can be fed in while earlier waves are still moving through the plane. Each wave then carries whatever program it happened to cross.

A wave enters with a vector of literals (for two variables: x0, its complement, x1, its complement) and a valid flag. Every row starts the wave's product at logic 1 with tag 0. Each token carries a term tag, and the wave takes the tag of the last token it met. Downstream logic can therefore tell which product term each output bit represents, even while the term assignment of a physical row rotates. Each row has its own token input, so rows are programmed independently. The products of all rows for one wave appear together on registered outputs.

Top module: `cf_pla_counterflow`

## Requirements
- R1: While reset is high, and on the first clock after it, `out_vld` is 0 and every bit of `out_prod` and `out_tag` is 0.
- R2: A wave accepted with `in_vld` high at clock edge t appears with `out_vld` high after edge t+STAGES. Waves may enter on consecutive clocks, and every accepted wave produces exactly one output.
- R3: A token accepted on a row at edge tc and a wave accepted at edge td meet exactly once when edge m = ceil((STAGES+tc+td)/2) satisfies td <= m <= td+STAGES and tc <= m <= tc+STAGES. Otherwise they never meet. No token passes a wave without meeting it, and no pair meets twice.
- R4: A met token with use bit 1 and literal index k (bit k of `in_lit`, LSB is index 0) clears the row's product when that literal of the wave is 0. A met token with use bit 0 leaves the product unchanged.
- R5: A wave that meets no token on a row leaves that row with product 1 and tag 0.
- R6: A row's output tag is the tag of the token the wave met at the latest edge. When two tokens are met at the same edge, the one accepted later wins.
- R7: A new program can be streamed in while waves are in flight. Each wave's result follows the tokens it actually met under R3, so waves in flight may mix the old and new programs.
- R8: Tokens given to one row have no effect on the product or tag of any other row.
- R9: An output slot with no wave behind it has `out_vld` 0 and all products and tags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | A data wave is present this cycle |
| in_lit | input | NLIT | Literal values of the wave, bit k is literal k |
| tok_vld | input | ROWS | Per-row token present |
| tok_use | input | ROWS | Per-row token includes its literal |
| tok_idx | input | ROWS*IDXW | Per-row literal index, row r in slice r |
| tok_tag | input | ROWS*TAGW | Per-row term tag, row r in slice r |
| out_vld | output | 1 | Output wave valid |
| out_prod | output | ROWS | Product bit of each row |
| out_tag | output | ROWS*TAGW | Term tag of each row, row r in slice r |

## Verification
On every cycle, the assertions check the following. Each node only clears and never sets the product. A node with no token present passes the product and tag through unchanged. A token at the crossing position sets the tag. Waves and tokens each advance one stage per clock. Bubbles leave the outputs at zero. Only the bench's scenarios can show the rest of the behaviour. This covers the meeting rule between waves and tokens (exactly once, inside the derived window), the latest-wins tag order, the mixing of programs during a mid-stream change, and the isolation between rows. The bench checks these by computing each expected product from the logged injection times of every wave and token.

// File: rtl/cf_pla_pkg.sv
package cf_pla_pkg;
  parameter int unsigned CF_ROWS_DFLT   = 4;
  parameter int unsigned CF_NLIT_DFLT   = 4;
  parameter int unsigned CF_STAGES_DFLT = 4;
  parameter int unsigned CF_TAGW_DFLT   = 2;

  function automatic int unsigned cf_idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cf_pla_wave_pipe.sv
module cf_pla_wave_pipe #(
  parameter int unsigned STAGES = 4,
  parameter int unsigned NLIT   = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld,
  input  logic [NLIT-1:0]             in_lit,
  output logic [STAGES:0]             vld_at,
  output logic [(STAGES+1)*NLIT-1:0]  lit_at,
  output logic                        out_vld
);
  logic [STAGES:0]   v_q;
  logic [NLIT-1:0]   l_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= {v_q[STAGES-1:0], in_vld};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) l_q[s] <= '0;
    end else begin
      l_q[0] <= in_lit;
      for (int s = 1; s < STAGES; s++) l_q[s] <= l_q[s-1];
    end
  end

  assign vld_at[0]          = in_vld;
  assign lit_at[NLIT-1:0]   = in_lit;

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_tap
      assign vld_at[g]                = v_q[g-1];
      assign lit_at[g*NLIT +: NLIT]   = l_q[g-1];
    end
    for (g = 0; g < STAGES; g++) begin : g_chk
      p_wave_step_r2: assert property (@(posedge clk) disable iff (rst)
        vld_at[g+1] |=> v_q[g+1]);
    end
  endgenerate

  assign out_vld = v_q[STAGES];
endmodule

// File: rtl/cf_pla_node.sv
module cf_pla_node #(
  parameter int unsigned NLIT = 4,
  parameter int unsigned IDXW = 2,
  parameter int unsigned TAGW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vin,
  input  logic [NLIT-1:0]  lit,
  input  logic             pp_in,
  input  logic [TAGW-1:0]  tag_in,
  input  logic             a_vld,
  input  logic             a_use,
  input  logic [IDXW-1:0]  a_idx,
  input  logic [TAGW-1:0]  a_tag,
  input  logic             b_vld,
  input  logic             b_use,
  input  logic [IDXW-1:0]  b_idx,
  input  logic [TAGW-1:0]  b_tag,
  output logic             pp_q,
  output logic [TAGW-1:0]  tag_q
);
  logic keep_a, keep_b, pp_nx;
  logic [TAGW-1:0] tag_nx;

  always_comb begin
    keep_a = !a_vld || !a_use || lit[a_idx];
    keep_b = !b_vld || !b_use || lit[b_idx];
    pp_nx  = pp_in && keep_a && keep_b;
    if (b_vld)      tag_nx = b_tag;
    else if (a_vld) tag_nx = a_tag;
    else            tag_nx = tag_in;
  end

  always_ff @(posedge clk) begin
    if (rst || !vin) begin
      pp_q  <= 1'b0;
      tag_q <= '0;
    end else begin
      pp_q  <= pp_nx;
      tag_q <= tag_nx;
    end
  end

  p_and_only_r4: assert property (@(posedge clk) disable iff (rst)
    (vin && !pp_in) |=> !pp_q);
  p_absent_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (vin && !a_vld && !b_vld) |=> (pp_q == $past(pp_in) && tag_q == $past(tag_in)));
  p_cross_tag_r6: assert property (@(posedge clk) disable iff (rst)
    (vin && b_vld) |=> (tag_q == $past(b_tag)));
  p_bubble_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !vin |=> (!pp_q && tag_q == '0));
endmodule

// File: rtl/cf_pla_row.sv
module cf_pla_row #(
  parameter int unsigned STAGES = 4,
  parameter int unsigned NLIT   = 4,
  parameter int unsigned IDXW   = 2,
  parameter int unsigned TAGW   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tk_vld,
  input  logic                        tk_use,
  input  logic [IDXW-1:0]             tk_idx,
  input  logic [TAGW-1:0]             tk_tag,
  input  logic [STAGES:0]             vld_at,
  input  logic [(STAGES+1)*NLIT-1:0]  lit_at,
  output logic                        prod,
  output logic [TAGW-1:0]             tag
);
  // control positions 0..STAGES; position STAGES is the token input
  logic             c_vld [STAGES+1];
  logic             c_use [STAGES+1];
  logic [IDXW-1:0]  c_idx [STAGES+1];
  logic [TAGW-1:0]  c_tag [STAGES+1];

  logic             pp_q  [STAGES+1];
  logic [TAGW-1:0]  tg_q  [STAGES+1];

  assign c_vld[STAGES] = tk_vld;
  assign c_use[STAGES] = tk_use;
  assign c_idx[STAGES] = tk_idx;
  assign c_tag[STAGES] = tk_tag;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_ctl
      always_ff @(posedge clk) begin
        if (rst) begin
          c_vld[k] <= 1'b0;
          c_use[k] <= 1'b0;
          c_idx[k] <= '0;
          c_tag[k] <= '0;
        end else begin
          c_vld[k] <= c_vld[k+1];
          c_use[k] <= c_use[k+1];
          c_idx[k] <= c_idx[k+1];
          c_tag[k] <= c_tag[k+1];
        end
      end
      p_tok_shift_r3: assert property (@(posedge clk) disable iff (rst)
        c_vld[k+1] |=> c_vld[k]);
    end

    for (k = 0; k <= STAGES; k++) begin : g_node
      if (k == 0) begin : g_head
        cf_pla_node #(.NLIT(NLIT), .IDXW(IDXW), .TAGW(TAGW)) u_node (
          .clk(clk), .rst(rst),
          .vin(vld_at[0]), .lit(lit_at[NLIT-1:0]),
          .pp_in(1'b1), .tag_in({TAGW{1'b0}}),
          .a_vld(1'b0), .a_use(1'b0), .a_idx({IDXW{1'b0}}), .a_tag({TAGW{1'b0}}),
          .b_vld(c_vld[0]), .b_use(c_use[0]), .b_idx(c_idx[0]), .b_tag(c_tag[0]),
          .pp_q(pp_q[0]), .tag_q(tg_q[0]));
      end else begin : g_body
        cf_pla_node #(.NLIT(NLIT), .IDXW(IDXW), .TAGW(TAGW)) u_node (
          .clk(clk), .rst(rst),
          .vin(vld_at[k]), .lit(lit_at[k*NLIT +: NLIT]),
          .pp_in(pp_q[k-1]), .tag_in(tg_q[k-1]),
          .a_vld(c_vld[k-1]), .a_use(c_use[k-1]), .a_idx(c_idx[k-1]), .a_tag(c_tag[k-1]),
          .b_vld(c_vld[k]), .b_use(c_use[k]), .b_idx(c_idx[k]), .b_tag(c_tag[k]),
          .pp_q(pp_q[k]), .tag_q(tg_q[k]));
      end
    end
  endgenerate

  assign prod = pp_q[STAGES];
  assign tag  = tg_q[STAGES];
endmodule

// File: rtl/cf_pla_counterflow.sv
module cf_pla_counterflow
  import cf_pla_pkg::*;
#(
  parameter int unsigned ROWS   = CF_ROWS_DFLT,
  parameter int unsigned NLIT   = CF_NLIT_DFLT,
  parameter int unsigned STAGES = CF_STAGES_DFLT,
  parameter int unsigned TAGW   = CF_TAGW_DFLT,
  localparam int unsigned IDXW  = cf_idx_w(NLIT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [NLIT-1:0]       in_lit,
  input  logic [ROWS-1:0]       tok_vld,
  input  logic [ROWS-1:0]       tok_use,
  input  logic [ROWS*IDXW-1:0]  tok_idx,
  input  logic [ROWS*TAGW-1:0]  tok_tag,
  output logic                  out_vld,
  output logic [ROWS-1:0]       out_prod,
  output logic [ROWS*TAGW-1:0]  out_tag
);
  logic [STAGES:0]             vld_at;
  logic [(STAGES+1)*NLIT-1:0]  lit_at;

  cf_pla_wave_pipe #(.STAGES(STAGES), .NLIT(NLIT)) u_wave (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_lit(in_lit),
    .vld_at(vld_at), .lit_at(lit_at), .out_vld(out_vld));

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      cf_pla_row #(.STAGES(STAGES), .NLIT(NLIT), .IDXW(IDXW), .TAGW(TAGW)) u_row (
        .clk(clk), .rst(rst),
        .tk_vld(tok_vld[r]), .tk_use(tok_use[r]),
        .tk_idx(tok_idx[r*IDXW +: IDXW]), .tk_tag(tok_tag[r*TAGW +: TAGW]),
        .vld_at(vld_at), .lit_at(lit_at),
        .prod(out_prod[r]), .tag(out_tag[r*TAGW +: TAGW]));
    end
  endgenerate

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_vld && out_prod == '0 && out_tag == '0));
endmodule

// File: tb/tb_cf_pla_counterflow.sv
module tb_cf_pla_counterflow;
  localparam int ROWS = 4, NLIT = 4, N = 4, TAGW = 2, IDXW = 2;
  localparam int GEN = 700, TOTAL = GEN + N + 3, MAXC = 1024;

  logic clk = 1'b0, rst = 1'b1;
  logic in_vld = 1'b0;
  logic [NLIT-1:0] in_lit = '0;
  logic [ROWS-1:0] tok_vld = '0, tok_use = '0;
  logic [ROWS*IDXW-1:0] tok_idx = '0;
  logic [ROWS*TAGW-1:0] tok_tag = '0;
  logic out_vld;
  logic [ROWS-1:0] out_prod;
  logic [ROWS*TAGW-1:0] out_tag;

  cf_pla_counterflow #(.ROWS(ROWS), .NLIT(NLIT), .STAGES(N), .TAGW(TAGW)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_lit(in_lit),
    .tok_vld(tok_vld), .tok_use(tok_use), .tok_idx(tok_idx), .tok_tag(tok_tag),
    .out_vld(out_vld), .out_prod(out_prod), .out_tag(out_tag));

  always #10 clk = ~clk;

  bit              wv [MAXC];
  logic [NLIT-1:0] wl [MAXC];
  bit              tv [ROWS][MAXC];
  bit              tu [ROWS][MAXC];
  logic [IDXW-1:0] ti [ROWS][MAXC];
  logic [TAGW-1:0] tt [ROWS][MAXC];

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_abcd;

  function automatic logic [31:0] nx(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected product/tag from meeting rule of R3
  task automatic expect_row(input int td, input int r, output bit pp,
                            output logic [TAGW-1:0] tg, output bit met);
    pp = 1'b1; tg = '0; met = 1'b0;
    for (int tc = (td - N < 0) ? 0 : td - N; tc <= td + N; tc++) begin
      if (tc < MAXC && tv[r][tc]) begin
        int m;
        m = (N + tc + td + 1) / 2;
        if (m >= td && m <= td + N && m >= tc && m <= tc + N) begin
          met = 1'b1;
          tg  = tt[r][tc];
          if (tu[r][tc] && !wl[td][ti[r][tc]]) pp = 1'b0;
        end
      end
    end
  endtask

  task automatic check_out(input int cyc);
    int td;
    td = cyc - 1 - N;
    if (td < 0) return;
    chk(out_vld == wv[td], wv[td] ? "R2" : "R9", out_vld, wv[td]);
    if (!wv[td]) begin
      chk(out_prod == '0 && out_tag == '0, "R9", {out_prod, out_tag}, 0);
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        bit pp, met;
        logic [TAGW-1:0] tg;
        string req;
        expect_row(td, r, pp, tg, met);
        if (td >= 400 && td < 550 && r > 0) req = "R8";
        else if (!met)                      req = "R5";
        else if (td >= 550)                 req = "R7";
        else if (td >= 100 && td < 250)     req = "R3";
        else                                req = "R4";
        chk(out_prod[r] == pp, req, out_prod[r], pp);
        chk(out_tag[r*TAGW +: TAGW] == tg, "R6", out_tag[r*TAGW +: TAGW], tg);
      end
    end
  endtask

  task automatic drive(input int cyc);
    logic [3:0] mA [ROWS];
    logic [3:0] mB [ROWS];
    mA[0] = 4'b0101; mA[1] = 4'b1001; mA[2] = 4'b0110; mA[3] = 4'b1010;
    mB[0] = 4'b1010; mB[1] = 4'b0110; mB[2] = 4'b1001; mB[3] = 4'b0101;
    seed = nx(seed);
    if (cyc >= GEN) begin
      in_vld = 1'b0; in_lit = '0; tok_vld = '0;
      return;
    end
    in_vld = (seed[1:0] != 2'b00);
    in_lit = (cyc < 100) ? cyc[3:0] : seed[7:4];
    for (int r = 0; r < ROWS; r++) begin
      logic [31:0] q;
      q = nx(seed ^ (32'h9e37_79b9 * (r + 1)));
      tok_use[r] = q[8];
      tok_idx[r*IDXW +: IDXW] = q[10:9];
      tok_tag[r*TAGW +: TAGW] = q[12:11];
      if (cyc < 100)      tok_vld[r] = 1'b0;
      else if (cyc < 250) tok_vld[r] = (q[2:0] == 3'b000);
      else if (cyc < 400) tok_vld[r] = q[0] | q[1];
      else if (cyc < 550) tok_vld[r] = (r == 0);
      else begin
        int k;
        k = cyc % 4;
        tok_vld[r] = 1'b1;
        tok_idx[r*IDXW +: IDXW] = k[1:0];
        tok_use[r] = (cyc < 620) ? mA[r][k] : mB[r][k];
        tok_tag[r*TAGW +: TAGW] = (cyc < 620) ? 2'(r) : 2'(3 - r);
      end
    end
    wv[cyc] = in_vld; wl[cyc] = in_lit;
    for (int r = 0; r < ROWS; r++) begin
      tv[r][cyc] = tok_vld[r]; tu[r][cyc] = tok_use[r];
      ti[r][cyc] = tok_idx[r*IDXW +: IDXW]; tt[r][cyc] = tok_tag[r*TAGW +: TAGW];
    end
  endtask

  initial begin
    // R1: drive activity during reset, outputs must stay clear
    in_vld = 1'b1; in_lit = '1; tok_vld = '1; tok_use = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_vld == 1'b0, "R1", out_vld, 0);
    chk(out_prod == '0, "R1", out_prod, 0);
    chk(out_tag == '0, "R1", out_tag, 0);
    for (int cyc = 0; cyc < TOTAL; cyc++) begin
      if (cyc > 0) @(negedge clk);
      rst = 1'b0;
      check_out(cyc);
      drive(cyc);
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule